// File: doc/BRIEF.md
# Serial Character Transmitter with Running Parity

This block turns a parallel character into an asynchronous serial frame on a single output line. A frame is a low start bit, the data bits least significant first, an optional parity bit and a high stop bit. When no frame is in progress, the line rests high at the mark level. The data length is either the full width or one bit shorter: 8 or 7 bits at the default width.

Parity is not taken from the whole word at load time. A one-bit accumulator is seeded when the character is accepted and is XORed with each data bit as that bit leaves the shift register. The parity work therefore overlaps the parallel-to-serial shift, and the result is ready by the time the last data bit has gone out.

A character is handed over with a valid/ready handshake. Length, parity enable and parity sense are captured together with the character. A periodic single-cycle tick input sets the bit time. The line starts the start bit only at the first tick after acceptance, so every bit on the line lasts exactly one tick period.

Top module: `ser_frame_tx`

## Requirements
- R1: While reset is applied, and whenever no frame is in progress, `line_o` is 1 (mark); `tx_ready_o` is 0 during reset.
- R2: Every frame begins with one start bit of value 0 and ends with one stop bit of value 1.
- R3: Data bits follow the start bit, least significant bit first.
- R4: With `cfg_short_i`=1 only the lower MAX_BITS-1 data bits are sent and the top bit of `tx_data_i` has no effect; with `cfg_short_i`=0 all MAX_BITS bits are sent.
- R5: With `cfg_par_en_i`=1 a parity bit is inserted between the last data bit and the stop bit. With `cfg_par_odd_i`=0 it makes the count of ones over data plus parity even; with `cfg_par_odd_i`=1 it makes that count odd. With `cfg_par_en_i`=0 no parity bit is sent.
- R6: The 7-bit character 0x61 with odd parity is sent as the 10-bit line sequence 0,1,0,0,0,0,1,1,0,1 (start, data LSB first, parity 0, stop).
- R7: A character is accepted on a clock edge where `tx_valid_i` and `tx_ready_o` are both 1. `tx_ready_o` then stays 0 until the stop bit ends, and any `tx_valid_i`/`tx_data_i` activity in that time is ignored.
- R8: `line_o` changes only on a clock edge where `bit_tick_i` is 1. The start bit begins at the first tick edge after acceptance, and each bit lasts from one tick edge to the next.
- R9: Length and parity settings are captured at acceptance; changes to the configuration inputs during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick_i | input | 1 | One-cycle pulse marking each bit boundary |
| tx_valid_i | input | 1 | A character is offered |
| tx_ready_o | output | 1 | Transmitter is idle and will take a character |
| tx_data_i | input | MAX_BITS | Character to send |
| cfg_short_i | input | 1 | 1: send MAX_BITS-1 data bits, 0: send MAX_BITS |
| cfg_par_en_i | input | 1 | Insert a parity bit |
| cfg_par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| line_o | output | 1 | Serial line, idle high |

## Verification
The hardest case to reach from the ports is a change in the inputs while a frame is in flight. Reaching it means offering a second character and flipping the length and parity settings after acceptance, and checking that the frame on the line still matches the settings that were captured. The bench does this in one scenario and drives junk data and valid pulses during the busy time. It also runs the tick at one-per-cycle and at slow, odd periods. This covers the single-cycle wait for the first tick and a long mark before the start bit.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic short_len;
    logic par_en;
    logic par_odd;
  } tx_cfg_t;

endpackage

// File: rtl/ser_tx_rstsync.sv
module ser_tx_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift #(
  parameter int MAX_BITS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic                odd_i,
  input  logic                shift_i,
  output logic                bit_o,
  output logic                par_o
);

  logic [MAX_BITS-1:0] sh_q, sh_d;
  logic                par_q, par_d;

  always_comb begin
    sh_d  = sh_q;
    par_d = par_q;
    if (load_i) begin
      sh_d  = data_i;
      par_d = odd_i;
    end else if (shift_i) begin
      par_d = par_q ^ sh_q[0];
      sh_d  = {1'b0, sh_q[MAX_BITS-1:1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      par_q <= 1'b0;
    end else if (load_i || shift_i) begin
      sh_q  <= sh_d;
      par_q <= par_d;
    end
  end

  assign bit_o = sh_q[0];
  assign par_o = par_q;

endmodule

// File: rtl/ser_tx_seq.sv
module ser_tx_seq
  import ser_tx_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int CNT_W    = 3
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      accept_i,
  input  tx_cfg_t   cfg_i,
  output tx_state_e state_o,
  output logic      shift_o
);

  localparam logic [CNT_W-1:0] LAST_FULL  = CNT_W'(MAX_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(MAX_BITS - 2);

  tx_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_idx;

  assign last_idx = cfg_i.short_len ? LAST_SHORT : LAST_FULL;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE:  if (accept_i) st_d = ST_ARM;
      ST_ARM:   if (tick_i)   st_d = ST_START;
      ST_START: if (tick_i) begin
        st_d  = ST_DATA;
        cnt_d = '0;
      end
      ST_DATA:  if (tick_i) begin
        if (cnt_q == last_idx) st_d = cfg_i.par_en ? ST_PAR : ST_STOP;
        else                   cnt_d = cnt_q + 1'b1;
      end
      ST_PAR:   if (tick_i)   st_d = ST_STOP;
      ST_STOP:  if (tick_i)   st_d = ST_IDLE;
      default:                st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o = st_q;
  assign shift_o = (st_q == ST_DATA) && tick_i;

endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx
  import ser_tx_pkg::*;
#(
  parameter int MAX_BITS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_tick_i,
  input  logic                tx_valid_i,
  output logic                tx_ready_o,
  input  logic [MAX_BITS-1:0] tx_data_i,
  input  logic                cfg_short_i,
  input  logic                cfg_par_en_i,
  input  logic                cfg_par_odd_i,
  output logic                line_o
);

  localparam int CNT_W = (MAX_BITS > 2) ? $clog2(MAX_BITS) : 1;

  logic      run_n;
  tx_state_e state;
  logic      shift_en;
  logic      accept;
  tx_cfg_t   cfg_q, cfg_d;
  logic      data_bit, par_bit;

  ser_tx_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(run_n)
  );

  assign tx_ready_o = (state == ST_IDLE) && run_n;
  assign accept     = tx_valid_i && tx_ready_o;

  assign cfg_d = '{short_len: cfg_short_i, par_en: cfg_par_en_i, par_odd: cfg_par_odd_i};

  always_ff @(posedge clk_i or negedge run_n) begin
    if (!run_n)      cfg_q <= '0;
    else if (accept) cfg_q <= cfg_d;
  end

  ser_tx_seq #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (run_n),
    .tick_i  (bit_tick_i),
    .accept_i(accept),
    .cfg_i   (cfg_q),
    .state_o (state),
    .shift_o (shift_en)
  );

  ser_tx_shift #(.MAX_BITS(MAX_BITS)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (run_n),
    .load_i (accept),
    .data_i (tx_data_i),
    .odd_i  (cfg_par_odd_i),
    .shift_i(shift_en),
    .bit_o  (data_bit),
    .par_o  (par_bit)
  );

  always_comb begin
    unique case (state)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = data_bit;
      ST_PAR:   line_o = par_bit;
      default:  line_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/ser_frame_tx_chk.sv
module ser_frame_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic run_i,
  input logic bit_tick_i,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic line_o
);

  // R1
  idle_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> line_o);

  // R8
  line_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_tick_i |=> $stable(line_o));

  // R7
  accept_only_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_ready_o) |-> $past(tx_valid_i));

  // R7
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tx_ready_o && !bit_tick_i) |=> !tx_ready_o);

  // R2
  no_early_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_ready_o) |-> line_o);

endmodule

bind ser_frame_tx ser_frame_tx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_i     (run_n),
  .bit_tick_i(bit_tick_i),
  .tx_valid_i(tx_valid_i),
  .tx_ready_o(tx_ready_o),
  .line_o    (line_o)
);

// File: tb/tb_ser_frame_tx.sv
module tb_ser_frame_tx;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       valid;
  logic       ready;
  logic [7:0] data;
  logic       c_short, c_pen, c_odd;
  logic       line;

  always #10 clk = ~clk;

  ser_frame_tx dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bit_tick_i   (tick),
    .tx_valid_i   (valid),
    .tx_ready_o   (ready),
    .tx_data_i    (data),
    .cfg_short_i  (c_short),
    .cfg_par_en_i (c_pen),
    .cfg_par_odd_i(c_odd),
    .line_o       (line)
  );

  int    total = 0;
  int    bad   = 0;
  int    per   = 4;
  int    tcnt  = 0;
  string tag   = "R1";
  bit    done  = 0;

  // reference model
  bit q[$];
  int mstate = 0;  // 0 idle, 1 waiting first tick, 2 sending
  bit mline  = 1;

  function automatic void build(input logic [7:0] d, input bit sh, input bit pe, input bit od);
    int n = sh ? 7 : 8;
    bit p = od;
    q.delete();
    q.push_back(1'b0);
    for (int i = 0; i < n; i++) begin
      q.push_back(d[i]);
      p = p ^ d[i];
    end
    if (pe) q.push_back(p);
    q.push_back(1'b1);
  endfunction

  task automatic check(input string t, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", t, what, act, exp, $time);
    end
  endtask

  task automatic step();
    tick = (tcnt == per - 1);
    @(posedge clk);
    case (mstate)
      0: if (valid) begin
        build(data, c_short, c_pen, c_odd);
        mstate = 1;
      end
      1: if (tick) begin
        mline  = q.pop_front();
        mstate = 2;
      end
      default: if (tick) begin
        if (q.size() == 0) begin
          mstate = 0;
          mline  = 1;
        end else mline = q.pop_front();
      end
    endcase
    tcnt = (tcnt + 1) % per;
    #2;
    check(tag, ready, (mstate == 0), "ready");
    check(tag, line, (mstate == 2) ? mline : 1'b1, "line");
  endtask

  task automatic send(input logic [7:0] d, input bit sh, input bit pe, input bit od,
                      input bit disturb);
    data = d; c_short = sh; c_pen = pe; c_odd = od; valid = 1'b1;
    while (mstate == 0) step();
    valid = 1'b0;
    if (disturb) begin
      // R7 / R9: junk offers and config flips while busy
      for (int k = 0; k < 3; k++) begin
        valid = 1'b1; data = ~d; c_short = ~sh; c_pen = ~pe; c_odd = ~od;
        step();
      end
      valid = 1'b0;
    end
    while (mstate != 0) step();
    step();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; valid = 1'b0; data = '0;
    c_short = 1'b0; c_pen = 1'b0; c_odd = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check("R1", line, 1'b1, "line in reset");
    check("R1", ready, 1'b0, "ready in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R1", ready, 1'b1, "ready after reset");
    check("R1", line, 1'b1, "idle line");

    // R6: known example, model sanity against literal frame
    build(8'h61, 1, 1, 1);
    begin
      bit exp_f[10] = '{0, 1, 0, 0, 0, 0, 1, 1, 0, 1};
      check("R6", (q.size() == 10), 1'b1, "frame length");
      for (int i = 0; i < 10; i++) check("R6", q[i], exp_f[i], "frame bit");
    end
    q.delete();

    tag = "R6"; send(8'h61, 1, 1, 1, 0);
    tag = "R3"; send(8'hA5, 0, 0, 0, 0);
    tag = "R5"; send(8'h3C, 0, 1, 0, 0);
    tag = "R5"; send(8'h3D, 0, 1, 1, 0);
    tag = "R4"; send(8'hE1, 1, 1, 1, 0);
    tag = "R4"; send(8'h80, 1, 0, 0, 0);
    tag = "R7"; send(8'h5A, 0, 1, 0, 1);
    tag = "R9"; send(8'hC3, 1, 0, 1, 1);
    per = 1;
    tag = "R8"; send(8'hFF, 0, 1, 1, 0);
    tag = "R8"; send(8'h00, 0, 1, 0, 0);
    per = 7; tcnt = 0;
    tag = "R2"; send(8'h96, 0, 1, 0, 1);
    tag = "R8"; send(8'h7F, 1, 1, 0, 0);
    // back-to-back offers: valid held through idle
    per = 3; tcnt = 0;
    tag = "R7";
    data = 8'h11; c_short = 0; c_pen = 0; c_odd = 0; valid = 1'b1;
    for (int c = 0; c < 70; c++) step();
    valid = 1'b0;
    while (mstate != 0) step();
    step();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule